// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI bus master that works through a queue of up to sixteen transfer entries. Each entry holds a command word, a transmit word and a receive word. The command word picks the four chip-select levels for that transfer and says whether the transfer uses the programmable word length or the default of eight bits. Software fills the command and transmit memories through a simple write port. It then sets the start and end pointers and issues a start command. The block shifts one word per entry, stores each received word in the receive memory and raises a done flag after the last entry.

The serial clock polarity and phase are selected independently, which gives all four SPI clock modes. The serial clock rate comes from an 8-bit divider. Between runs the clock and chip-select pins are driven from an idle-level register, so software can make the handover free of glitches. Master mode must be enabled to start a run. If the slave-select input goes low while master mode is enabled, the block flags a mode fault. It then aborts the queue, hands the pins back to their idle levels and clears the master enable. A wired-OR enable bit is passed out as a flag that applies to every pin.

Top module: `qspi_master`

## Requirements
- R1: Control bit 12 sets the serial clock rest level, and control bit 13 selects the phase. With phase 0, MISO is sampled on the first (leading) edge of each bit and MOSI changes on the trailing edge. With phase 1 the roles of the two edges swap. The clock stands at the rest level when each entry starts and when it ends.
- R2: Words are shifted most significant bit first on MOSI and on MISO.
- R3: An entry whose command bit 4 is set transfers N bits, where N is the value of control bits [11:8] if that value is 8 to 15, and 16 if the value is 0 to 7. An entry with command bit 4 clear transfers 8 bits. Each received word is right-justified, with its upper bits zero.
- R4: The serial clock half-period is max(B,1)+1 system clocks, where B is control bits [7:0].
- R5: Writing 1 to bit 0 at address 0x03 while control bit 14 (master enable) is set and the queue is idle runs the entries from the start pointer (address 0x01, bits [3:0]) to the end pointer (address 0x01, bits [7:4]). The pointer wraps modulo 16. At the end the block sets the done flag (status bit 0) and returns to idle. A start issued while the master enable is clear is ignored.
- R6: During an entry, pcs carries bits [3:0] of that entry's command word (command memory at 0x20+i).
- R7: While the queue is idle, sck equals bit 0 and pcs equals bits [4:1] of the idle-level register at address 0x02.
- R8: If ss_n is low while the master enable is set, then from the next clock the status bit 1 (mode fault) is set, the queue is stopped (status bit 2 busy clear), the pins show their idle levels and control bit 14 reads 0.
- R9: wired_or follows control bit 15.
- R10: Status (address 0x04) shows the current entry pointer in bits [7:4]. Transmit words are written and received words are read at 0x40+i.
- R11: After reset the control register, the status and the pins sck, pcs and wired_or are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register and memory write strobe |
| wr_addr | input | 7 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 7 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| pcs | output | 4 | Peripheral chip selects |
| ss_n | input | 1 | Slave-select input, active low |
| wired_or | output | 1 | Open-drain enable flag for all pins |

## Verification
A wrong edge counter or shift register shows up at once as a bad bit in the word that the slave model collects from MOSI. It also shows up in the receive memory as soon as the entry ends. A bad divider state changes the spacing of the sck edges on the next half-period. A bad pointer or queue state shows up as a wrong chip-select value at the next sample edge, as entries written to the wrong slots, or as a pointer that reads back wrong when the run ends. A fault path that fails to clear the enable or to release the pins is seen one clock after ss_n falls.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
    localparam int QA_W   = 4;
    localparam int QDEPTH = 1 << QA_W;
    localparam int WORD_W = 16;
    localparam int LEN_W  = 5;
    localparam int EDGE_W = LEN_W + 1;
    localparam int BAUD_W = 8;
    localparam int NPCS   = 4;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] A_CTRL = 7'h00;
    localparam logic [ADDR_W-1:0] A_PTR  = 7'h01;
    localparam logic [ADDR_W-1:0] A_IDLE = 7'h02;
    localparam logic [ADDR_W-1:0] A_GO   = 7'h03;
    localparam logic [ADDR_W-1:0] A_STAT = 7'h04;
    localparam logic [2:0] REG_CMD  = 3'b010;
    localparam logic [2:0] REG_DATA = 3'b100;

    typedef struct packed {
        logic              wom;
        logic              mstr;
        logic              cpha;
        logic              cpol;
        logic [3:0]        bits;
        logic [BAUD_W-1:0] baud;
    } ctrl_t;

    typedef struct packed {
        logic            len_en;
        logic [NPCS-1:0] pcs;
    } cmd_t;

    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT} qstate_t;

    function automatic logic [LEN_W-1:0] word_len(input logic len_en, input logic [3:0] bits);
        if (!len_en)
            return LEN_W'(8);
        if (bits < 4'd8)
            return LEN_W'(16);
        return {1'b0, bits};
    endfunction
endpackage

// File: rtl/qspi_clkdiv.sv
module qspi_clkdiv
    import qspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [BAUD_W-1:0] baud,
    output logic              tick
);
    logic [BAUD_W-1:0] cnt;
    logic [BAUD_W-1:0] div;

    assign div  = (baud == '0) ? BAUD_W'(1) : baud;
    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick)
            cnt <= '0;
        else
            cnt <= cnt + BAUD_W'(1);
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);  // R4
endmodule

// File: rtl/qspi_shifter.sv
module qspi_shifter
    import qspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              tick,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [LEN_W-1:0]  nbits,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              sck_o,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word,
    output logic              word_done
);
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;
    logic [EDGE_W-1:0] edge_q;
    logic              lead;
    logic              last;

    assign lead    = ~edge_q[0];
    assign last    = tick && (edge_q == ({nbits, 1'b0} - EDGE_W'(1)));
    assign mosi    = tx_sh[WORD_W-1];
    assign rx_word = rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh     <= '0;
            rx_sh     <= '0;
            edge_q    <= '0;
            sck_o     <= 1'b0;
            word_done <= 1'b0;
        end else if (load) begin
            tx_sh     <= tx_word << (LEN_W'(WORD_W) - nbits);
            rx_sh     <= '0;
            edge_q    <= '0;
            sck_o     <= cpol;
            word_done <= 1'b0;
        end else begin
            word_done <= last;
            if (tick) begin
                sck_o  <= ~sck_o;
                edge_q <= edge_q + EDGE_W'(1);
                if (lead ^ cpha)
                    rx_sh <= {rx_sh[WORD_W-2:0], miso};
                else if (edge_q != '0)
                    tx_sh <= tx_sh << 1;
            end
        end
    end

    AST_SCK_HOME: assert property (@(posedge clk) disable iff (rst)
        word_done |-> (sck_o == cpol));  // R1
    AST_RX_JUSTIFY: assert property (@(posedge clk) disable iff (rst)
        word_done |-> ((rx_sh >> nbits) == '0));  // R3
endmodule

// File: rtl/qspi_master.sv
module qspi_master
    import qspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NPCS-1:0]   pcs,
    input  logic              ss_n,
    output logic              wired_or
);
    ctrl_t             ctrl;
    qstate_t           state;
    logic [QA_W-1:0]   q_start, q_end, cur;
    logic              idle_sck;
    logic [NPCS-1:0]   idle_pcs;
    logic              done_f, modf_f;
    cmd_t              cmd_mem [QDEPTH];
    logic [WORD_W-1:0] tx_mem  [QDEPTH];
    logic [WORD_W-1:0] rx_mem  [QDEPTH];

    cmd_t              cur_cmd;
    logic [LEN_W-1:0]  nbits;
    logic              busy, modf_hit, go_wr, tick, sck_sh, word_done;
    logic [WORD_W-1:0] rx_word;
    logic [QA_W-1:0]   w_idx;

    assign cur_cmd  = cmd_mem[cur];
    assign nbits    = word_len(cur_cmd.len_en, ctrl.bits);
    assign busy     = (state != ST_IDLE);
    assign modf_hit = ctrl.mstr && !ss_n;
    assign go_wr    = wr_en && (wr_addr == A_GO) && wr_data[0];
    assign w_idx    = wr_addr[QA_W-1:0];

    qspi_clkdiv u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_SHIFT),
        .baud (ctrl.baud),
        .tick (tick)
    );

    qspi_shifter u_sh (
        .clk       (clk),
        .rst       (rst),
        .load      (state == ST_LOAD),
        .tick      (tick),
        .cpol      (ctrl.cpol),
        .cpha      (ctrl.cpha),
        .nbits     (nbits),
        .tx_word   (tx_mem[cur]),
        .miso      (miso),
        .sck_o     (sck_sh),
        .mosi      (mosi),
        .rx_word   (rx_word),
        .word_done (word_done)
    );

    always_comb begin
        unique case (state)
            ST_SHIFT: sck = sck_sh;
            ST_LOAD:  sck = ctrl.cpol;
            default:  sck = idle_sck;
        endcase
        pcs      = busy ? cur_cmd.pcs : idle_pcs;
        wired_or = ctrl.wom;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL)
            rd_data = ctrl;
        else if (rd_addr == A_PTR)
            rd_data = {8'd0, q_end, q_start};
        else if (rd_addr == A_IDLE)
            rd_data = {11'd0, idle_pcs, idle_sck};
        else if (rd_addr == A_STAT)
            rd_data = {8'd0, cur, 1'b0, busy, modf_f, done_f};
        else if (rd_addr[ADDR_W-1:QA_W] == REG_DATA)
            rd_data = rx_mem[rd_addr[QA_W-1:0]];
        else if (rd_addr[ADDR_W-1:QA_W] == REG_CMD)
            rd_data = {11'd0, cmd_mem[rd_addr[QA_W-1:0]]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            state    <= ST_IDLE;
            q_start  <= '0;
            q_end    <= '0;
            cur      <= '0;
            idle_sck <= 1'b0;
            idle_pcs <= '0;
            done_f   <= 1'b0;
            modf_f   <= 1'b0;
            for (int i = 0; i < QDEPTH; i++) begin
                cmd_mem[i] <= '0;
                tx_mem[i]  <= '0;
                rx_mem[i]  <= '0;
            end
        end else begin
            if (wr_en) begin
                if (wr_addr == A_CTRL)
                    ctrl <= wr_data;
                else if (wr_addr == A_PTR)
                    {q_end, q_start} <= wr_data[2*QA_W-1:0];
                else if (wr_addr == A_IDLE)
                    {idle_pcs, idle_sck} <= wr_data[NPCS:0];
                else if (wr_addr[ADDR_W-1:QA_W] == REG_CMD)
                    cmd_mem[w_idx] <= wr_data[NPCS:0];
                else if (wr_addr[ADDR_W-1:QA_W] == REG_DATA)
                    tx_mem[w_idx] <= wr_data;
            end
            unique case (state)
                ST_IDLE: if (go_wr && ctrl.mstr) begin
                    state  <= ST_LOAD;
                    cur    <= q_start;
                    done_f <= 1'b0;
                    modf_f <= 1'b0;
                end
                ST_LOAD: state <= ST_SHIFT;
                default: if (word_done) begin
                    rx_mem[cur] <= rx_word;
                    if (cur == q_end) begin
                        state  <= ST_IDLE;
                        done_f <= 1'b1;
                    end else begin
                        cur   <= cur + QA_W'(1);
                        state <= ST_LOAD;
                    end
                end
            endcase
            if (modf_hit) begin
                modf_f    <= 1'b1;
                ctrl.mstr <= 1'b0;
                state     <= ST_IDLE;
            end
        end
    end

    AST_MODF_ABORT: assert property (@(posedge clk) disable iff (rst)
        modf_hit |=> (state == ST_IDLE && modf_f && !ctrl.mstr));  // R8
    AST_PCS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && $past(state) == ST_SHIFT) |-> $stable(pcs));  // R6
    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && $past(state) == ST_IDLE && !$past(wr_en && wr_addr == A_IDLE))
            |-> ($stable(sck) && $stable(pcs)));  // R7
    AST_NO_SLAVE_START: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !ctrl.mstr) |=> (state == ST_IDLE));  // R5
endmodule

// File: tb/sim_qspi_master.sv
module sim_qspi_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [6:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        sck, mosi, wired_or;
    logic        miso = 1'b0;
    logic        ss_n = 1'b1;
    logic [3:0]  pcs;

    qspi_master u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sck(sck), .mosi(mosi), .miso(miso),
        .pcs(pcs), .ss_n(ss_n), .wired_or(wired_or)
    );

    always #2.5 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit reported = 0;

    // bench configuration and queue image
    bit         cfg_cpol, cfg_cpha;
    logic [3:0] cfg_bits;
    logic [7:0] cfg_baud;
    int         cfg_half;
    logic [4:0] b_cmd [16];
    logic [15:0] b_tx [16];
    logic [15:0] b_sw [16];
    logic [15:0] sl_got [16];

    // slave model state
    bit          sl_active = 0;
    int          sl_entry = 0, sl_cnt = 0, sl_ec = 0, sl_gap = 0;
    logic [15:0] sl_cur = '0;
    logic        prev_sck = 1'b0;

    function automatic int elen(input logic [4:0] cmd, input logic [3:0] bits);
        if (cmd[4] == 1'b0) return 8;
        if (bits >= 4'd8) return int'(bits);
        return 16;
    endfunction

    function automatic logic [15:0] wmask(input int n);
        return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    // serial slave model: clocked by observation away from the active edge
    always @(negedge clk) begin
        int n, n2;
        bit lead;
        sl_gap++;
        if (sl_active && sck !== prev_sck) begin
            n = elen(b_cmd[sl_entry], cfg_bits);
            lead = (sck != cfg_cpol);
            if (sl_ec > 0) chk(sl_gap == cfg_half, "R4 half-period", sl_gap, cfg_half);
            sl_gap = 0;
            if (lead ^ cfg_cpha) begin
                chk(pcs == b_cmd[sl_entry][3:0], "R6 pcs", pcs, b_cmd[sl_entry][3:0]);
                sl_cur = {sl_cur[14:0], mosi};
                sl_cnt++;
            end
            sl_ec++;
            if (sl_ec == 2 * n) begin
                sl_got[sl_entry] = sl_cur;
                sl_cur = '0; sl_cnt = 0; sl_ec = 0;
                sl_entry = (sl_entry + 1) % 16;
            end
        end
        prev_sck = sck;
        n2 = elen(b_cmd[sl_entry], cfg_bits);
        miso = (sl_cnt < n2) ? b_sw[sl_entry][n2 - 1 - sl_cnt] : 1'b0;
    end

    task automatic program_cfg();
        cfg_half = ((cfg_baud == 0) ? 1 : int'(cfg_baud)) + 1;
        wr(7'h00, {1'b0, 1'b1, cfg_cpha, cfg_cpol, cfg_bits, cfg_baud});
    endtask

    // runs entries s..s+c-1 (mod 16) with the loaded image; idle sck matches cpol
    task automatic do_run(input int s, input int c, input logic [3:0] ipcs);
        int e;
        logic [15:0] d;
        bit fin;
        e = (s + c - 1) % 16;
        wr(7'h02, {11'd0, ipcs, cfg_cpol});
        wr(7'h01, {8'd0, 4'(e), 4'(s)});
        for (int i = 0; i < 16; i++) begin
            wr(7'h20 + 7'(i), {11'd0, b_cmd[i]});
            wr(7'h40 + 7'(i), b_tx[i]);
        end
        sl_entry = s; sl_cnt = 0; sl_ec = 0; sl_cur = '0;
        @(negedge clk);
        sl_active = 1;
        wr(7'h03, 16'h0001);
        fin = 0;
        for (int k = 0; k < 8000 && !fin; k++) begin
            @(negedge clk);
            rd(7'h04, d);
            fin = d[0];
        end
        sl_active = 0;
        chk(fin, "R5 done flag", int'(fin), 1);
        rd(7'h04, d);
        chk(d[2] == 1'b0, "R5 idle after run", d[2], 0);
        chk(d[7:4] == 4'(e), "R10 current pointer", d[7:4], e);
        chk(sck == cfg_cpol, "R7 idle sck", sck, cfg_cpol);
        chk(pcs == ipcs, "R7 idle pcs", pcs, ipcs);
        for (int j = 0; j < c; j++) begin
            int x, n;
            x = (s + j) % 16;
            n = elen(b_cmd[x], cfg_bits);
            rd(7'h40 + 7'(x), d);
            chk(d == (b_sw[x] & wmask(n)), "R2 R3 rx word", d, b_sw[x] & wmask(n));
            chk(sl_got[x] == (b_tx[x] & wmask(n)), "R1 R2 mosi word", sl_got[x], b_tx[x] & wmask(n));
        end
    endtask

    task automatic fill_random();
        for (int i = 0; i < 16; i++) begin
            b_cmd[i] = 5'($urandom);
            b_tx[i]  = 16'($urandom);
            b_sw[i]  = 16'($urandom);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        report();
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        rd(7'h00, d); chk(d == 16'h0, "R11 ctrl reset", d, 0);
        rd(7'h04, d); chk(d == 16'h0, "R11 status reset", d, 0);
        chk(sck == 1'b0 && pcs == 4'h0, "R11 pins reset", {pcs, sck}, 0);
        chk(wired_or == 1'b0, "R11 wired_or reset", wired_or, 0);

        // R9 wired-OR flag
        wr(7'h00, 16'h8000);
        chk(wired_or == 1'b1, "R9 wired_or set", wired_or, 1);
        wr(7'h00, 16'h0000);
        chk(wired_or == 1'b0, "R9 wired_or clear", wired_or, 0);

        // R5 start ignored while master enable is clear
        wr(7'h02, 16'h001E);
        wr(7'h03, 16'h0001);
        repeat (20) @(negedge clk);
        rd(7'h04, d);
        chk(d[2] == 1'b0 && d[0] == 1'b0, "R5 start ignored", d, 0);
        chk(pcs == 4'hF && sck == 1'b0, "R5 R7 pins idle when ignored", {pcs, sck}, 5'h1E);

        // R3 directed: length field below 8 means 16, clear enable means 8
        fill_random();
        cfg_cpol = 0; cfg_cpha = 0; cfg_bits = 4'd3; cfg_baud = 8'd0;
        b_cmd[0] = 5'h1A; b_cmd[1] = 5'h05;
        program_cfg();
        do_run(0, 2, 4'hF);

        // R1 R3 directed: all modes, length 8 and 15, wrapping queue
        for (int m = 0; m < 4; m++) begin
            fill_random();
            cfg_cpol = m[0]; cfg_cpha = m[1];
            cfg_bits = (m < 2) ? 4'd15 : 4'd8;
            cfg_baud = 8'(m);
            program_cfg();
            do_run(14, 4, 4'(m + 3));
        end

        // random runs
        for (int r = 0; r < 24; r++) begin
            fill_random();
            cfg_cpol = 1'($urandom); cfg_cpha = 1'($urandom);
            cfg_bits = 4'($urandom); cfg_baud = 8'($urandom_range(0, 3));
            program_cfg();
            do_run(int'($urandom_range(0, 15)), int'($urandom_range(1, 4)), 4'($urandom));
        end

        // R8 mode fault in the middle of a run
        fill_random();
        cfg_cpol = 1; cfg_cpha = 0; cfg_bits = 4'd0; cfg_baud = 8'd3;
        for (int i = 0; i < 16; i++) b_cmd[i] = {1'b1, 4'h2};
        program_cfg();
        wr(7'h02, 16'h001F);
        wr(7'h01, 16'h0030);
        for (int i = 0; i < 4; i++) wr(7'h20 + 7'(i), {11'd0, b_cmd[i]});
        wr(7'h03, 16'h0001);
        repeat (40) @(negedge clk);
        rd(7'h04, d);
        chk(d[2] == 1'b1, "R5 busy before fault", d[2], 1);
        chk(pcs == 4'h2, "R6 pcs during run", pcs, 2);
        ss_n = 1'b0;
        @(negedge clk);
        rd(7'h04, d);
        chk(d[1] == 1'b1, "R8 fault flag", d[1], 1);
        chk(d[2] == 1'b0, "R8 queue stopped", d[2], 0);
        chk(sck == 1'b1 && pcs == 4'hF, "R8 pins idle", {pcs, sck}, 5'h1F);
        rd(7'h00, d);
        chk(d[14] == 1'b0, "R8 master enable cleared", d[14], 0);
        ss_n = 1'b1;
        wr(7'h03, 16'h0001);
        repeat (10) @(negedge clk);
        rd(7'h04, d);
        chk(d[2] == 1'b0 && d[1] == 1'b1, "R5 start ignored after fault", d[2:0], 3'b010);

        // recovery run after re-enabling master mode
        fill_random();
        cfg_cpol = 0; cfg_cpha = 1; cfg_bits = 4'd12; cfg_baud = 8'd1;
        program_cfg();
        do_run(5, 3, 4'hE);

        report();
    end
endmodule